// File: doc/BRIEF.md
# Rotating Self-Checked Sparse Prefix Adder

This block is a 16-bit adder with a fault-tolerance mechanism built into its sum path. A parallel-prefix carry network produces only the carries at the segment boundaries. Four 4-bit ripple segments then form the sum slices from those boundary carries. The lowest segment takes the external carry-in.

A rotating index picks one segment in each clock cycle. Two shared checker ripple adders recompute the picked slice from the same operand bits and carry-in. A two-of-three vote decides the value of that slice. When both checkers agree with each other but not with the segment, the error flag rises and the failing index is recorded. From then on the index stops rotating, and a single spare ripple adder takes the place of the failed segment.

A test-only injection input inverts the output of one chosen segment. This lets the detection and repair path be exercised from the ports.

Top module: `seg_vote_adder`

## Requirements
- R1: With fault_en low, {cout, sum} equals op_a + op_b + cin in the same cycle, with no clock edge in between.
- R2: The segment under test is 0 in the first cycle after reset release and advances by one, wrapping 3 to 0, on each rising edge while no error is recorded. A fault present on segment s from reset release therefore sets err on the (s+1)-th rising edge.
- R3: In the cycle in which a faulty segment is under test, its sum slice carries the correct value.
- R4: fault_en high inverts all four output bits of segment fault_seg, which drives sum bits 4*fault_seg+3 down to 4*fault_seg. While that segment is not under test and no error is recorded, that slice is inverted and every other slice is correct.
- R5: When the checkers agree with each other but differ from the tested segment, err rises at the next edge and err_seg takes that segment's index. Both hold until reset, even after the fault disappears.
- R6: After err is set, a fault on the segment named by err_seg no longer affects sum.
- R7: After err is set, the tested index stays frozen. A fault injected on any other segment appears uncorrected in sum, and err and err_seg do not change.
- R8: A fault that appears in any cycle before the first error sets err within 1 to 4 rising edges.
- R9: While rst_n is low at a rising edge, err is cleared and err_seg returns to 0.
- R10: cout comes from the prefix network and equals the true carry-out of op_a + op_b + cin, even under fault injection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| cin | input | 1 | Carry into bit 0 |
| fault_en | input | 1 | Test only: invert one segment's output |
| fault_seg | input | 2 | Test only: index of the segment to corrupt |
| sum | output | 16 | Voted and repaired sum |
| cout | output | 1 | Carry out of bit 15 |
| err | output | 1 | Sticky fault-detected flag |
| err_seg | output | 2 | Index of the segment found faulty |

## Verification
The hardest situation to reach is the exact cycle in which the rotating index meets the faulty segment, because the index cannot be seen at the ports. The bench carries its own model of the index, which starts at 0 after reset release and steps once per edge. For every fault segment it starts the injection after 0 to 4 clean cycles, so every index-to-fault offset is covered. It then predicts, for each cycle, which slice is voted correct, which is inverted, and on which edge err must rise. After repair, it moves the injection to a neighbouring segment to reach the uncorrected second-fault case.

// File: rtl/seg_vote_pkg.sv
// Package: shared defaults and the voter outcome type for the
// self-checked sparse adder. Assumes nothing beyond IEEE 1800-2017.
package seg_vote_pkg;
    localparam int DEF_SEG_W = 4;
    localparam int DEF_N_SEG = 4;

    // Result of comparing one segment with its two checker adders
    typedef enum logic [1:0] {
        VOTE_MAIN  = 2'd0,  // segment agrees with at least one checker
        VOTE_TESTS = 2'd1,  // checkers agree, segment disagrees
        VOTE_SPLIT = 2'd2   // all three differ; segment value kept
    } vote_t;
endpackage

// File: rtl/ks_sparse_carry.sv
// Kogge-Stone style prefix network that computes group generate and
// propagate over W bits, then exports only the carries at every STEP-bit
// boundary (index 0 is the external carry-in, index W/STEP the carry-out).
// Assumes W is a multiple of STEP.
module ks_sparse_carry #(
    parameter int W    = 16,
    parameter int STEP = 4,
    localparam int LV  = $clog2(W),
    localparam int NB  = W / STEP
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [NB:0]  carry
);
    logic [LV:0][W-1:0] gv;
    logic [LV:0][W-1:0] pv;

    // Prefix tree: each level combines spans doubled in length
    always_comb begin
        gv[0] = a & b;
        pv[0] = a ^ b;
        for (int l = 0; l < LV; l++) begin
            gv[l+1] = gv[l];
            pv[l+1] = pv[l];
            for (int i = (1 << l); i < W; i++) begin
                gv[l+1][i] = gv[l][i] | (pv[l][i] & gv[l][i-(1<<l)]);
                pv[l+1][i] = pv[l][i] & pv[l][i-(1<<l)];
            end
        end
    end

    assign carry[0] = cin;
    // Boundary carries only: the sparse tap points
    for (genvar k = 1; k <= NB; k++) begin : g_tap
        assign carry[k] = gv[LV][k*STEP-1] | (pv[LV][k*STEP-1] & cin);
    end
endmodule

// File: rtl/ripple_seg.sv
// Plain ripple-carry adder for one SEG_W-bit slice. Used for the main
// segments, the two checker adders and the spare. Carry-out is not
// exported, since boundary carries come from the prefix network.
module ripple_seg #(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W-1:0] x,
    input  logic [SEG_W-1:0] y,
    input  logic             ci,
    output logic [SEG_W-1:0] s
);
    logic cr;

    // Bit-serial carry chain across the slice
    always_comb begin
        cr = ci;
        for (int i = 0; i < SEG_W; i++) begin
            s[i] = x[i] ^ y[i] ^ cr;
            cr   = (x[i] & y[i]) | (cr & (x[i] ^ y[i]));
        end
    end
endmodule

// File: rtl/seg_voter.sv
// Two-of-three vote between a segment result and two checker results.
// The checkers' value wins only when the two agree; otherwise the
// segment value passes. Flags the case "checkers agree, segment differs".
module seg_voter
    import seg_vote_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W-1:0] main_s,
    input  logic [SEG_W-1:0] t_a,
    input  logic [SEG_W-1:0] t_b,
    output logic [SEG_W-1:0] pick,
    output vote_t            outcome
);
    // Majority selection and outcome classification
    always_comb begin
        if (t_a == t_b && t_a != main_s) begin
            pick    = t_a;
            outcome = VOTE_TESTS;
        end else if (main_s == t_a || main_s == t_b) begin
            pick    = main_s;
            outcome = VOTE_MAIN;
        end else begin
            pick    = main_s;
            outcome = VOTE_SPLIT;
        end
    end
endmodule

// File: rtl/seg_vote_adder.sv
// Top: sparse prefix adder whose ripple segments are checked one per
// cycle by two shared checker adders and a vote. On a disagreement the
// error is latched, the rotation freezes and a single spare replaces the
// failed segment. fault_en/fault_seg are test-only and corrupt one main
// segment (never the checkers or the spare). Reset is synchronous, active low.
module seg_vote_adder
    import seg_vote_pkg::*;
#(
    parameter int SEG_W = DEF_SEG_W,
    parameter int N_SEG = DEF_N_SEG,
    localparam int W    = SEG_W * N_SEG,
    localparam int IW   = $clog2(N_SEG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic          cin,
    input  logic          fault_en,
    input  logic [IW-1:0] fault_seg,
    output logic [W-1:0]  sum,
    output logic          cout,
    output logic          err,
    output logic [IW-1:0] err_seg
);
    logic [N_SEG:0]                seg_cin;
    logic [N_SEG-1:0][SEG_W-1:0]   a_sl, b_sl, main_raw, main_out, slot_sum, out_sl;
    logic [1:0][SEG_W-1:0]         test_s;
    logic [SEG_W-1:0]              spare_s, voted;
    vote_t                         vote_res;
    logic [IW-1:0]                 cnt_q, err_seg_q;
    logic                          err_q, det;

    assign a_sl = op_a;
    assign b_sl = op_b;

    ks_sparse_carry #(.W(W), .STEP(SEG_W)) u_carry (
        .a(op_a), .b(op_b), .cin(cin), .carry(seg_cin)
    );

    // Main segments, injection mux, spare substitution and final merge
    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
        ripple_seg #(.SEG_W(SEG_W)) u_main (
            .x(a_sl[k]), .y(b_sl[k]), .ci(seg_cin[k]), .s(main_raw[k])
        );
        assign main_out[k] = main_raw[k] ^ {SEG_W{fault_en && fault_seg == IW'(k)}};
        assign slot_sum[k] = (err_q && err_seg_q == IW'(k)) ? spare_s : main_out[k];
        assign out_sl[k]   = (cnt_q == IW'(k)) ? voted : slot_sum[k];
    end

    // Two checker adders fed with the slice under test
    for (genvar t = 0; t < 2; t++) begin : g_test
        ripple_seg #(.SEG_W(SEG_W)) u_test (
            .x(a_sl[cnt_q]), .y(b_sl[cnt_q]), .ci(seg_cin[cnt_q]), .s(test_s[t])
        );
    end

    ripple_seg #(.SEG_W(SEG_W)) u_spare (
        .x(a_sl[err_seg_q]), .y(b_sl[err_seg_q]), .ci(seg_cin[err_seg_q]), .s(spare_s)
    );

    seg_voter #(.SEG_W(SEG_W)) u_vote (
        .main_s(slot_sum[cnt_q]), .t_a(test_s[0]), .t_b(test_s[1]),
        .pick(voted), .outcome(vote_res)
    );

    assign det = !err_q && (vote_res == VOTE_TESTS);

    // Rotating test index; holds on detection and after an error
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!err_q && !det)
            cnt_q <= (cnt_q == IW'(N_SEG-1)) ? '0 : cnt_q + 1'b1;
    end

    // Sticky error flag and failed-segment capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            err_seg_q <= '0;
        end else if (det) begin
            err_q     <= 1'b1;
            err_seg_q <= cnt_q;
        end
    end

    assign sum     = out_sl;
    assign cout    = seg_cin[N_SEG];
    assign err     = err_q;
    assign err_seg = err_seg_q;
endmodule

// File: rtl/seg_vote_adder_chk.sv
// Checker for seg_vote_adder: relates port values to arithmetic truth
// and follows the internal test index. Attached with bind below.
module seg_vote_adder_chk #(
    parameter int SEG_W = 4,
    parameter int N_SEG = 4,
    localparam int W    = SEG_W * N_SEG,
    localparam int IW   = $clog2(N_SEG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  op_a,
    input logic [W-1:0]  op_b,
    input logic          cin,
    input logic          fault_en,
    input logic [IW-1:0] fault_seg,
    input logic [W-1:0]  sum,
    input logic          cout,
    input logic          err,
    input logic [IW-1:0] err_seg,
    input logic [IW-1:0] cnt_q,
    input logic          det
);
    logic [W:0] ref_full;
    assign ref_full = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, cin};

    assert_clean_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_en |-> {cout, sum} == ref_full);

    assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && !det) |=> cnt_q == (($past(cnt_q) == IW'(N_SEG-1)) ? '0 : $past(cnt_q) + 1'b1));

    assert_vote_slice_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_en |-> sum[int'(cnt_q)*SEG_W +: SEG_W] == ref_full[int'(cnt_q)*SEG_W +: SEG_W]);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && $stable(err_seg)));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> err_seg == $past(cnt_q));

    assert_spare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && fault_en && fault_seg == err_seg) |-> {cout, sum} == ref_full);

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> $stable(cnt_q));

    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (!err && err_seg == '0));

    assert_cout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cout == ref_full[W]);
endmodule

bind seg_vote_adder seg_vote_adder_chk #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .cin(cin),
    .fault_en(fault_en), .fault_seg(fault_seg), .sum(sum), .cout(cout),
    .err(err), .err_seg(err_seg), .cnt_q(cnt_q), .det(det)
);

// File: tb/seg_vote_adder_bench.sv
`timescale 1ns/1ps
// Bench: keeps its own model of the rotating index and error state and
// predicts sum, cout, err and err_seg arithmetically in every cycle.
module seg_vote_adder_bench;
    localparam int SEG_W = 4;
    localparam int N_SEG = 4;
    localparam int W     = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic          cin = 1'b0;
    logic          fault_en = 1'b0;
    logic [1:0]    fault_seg = '0;
    logic [W-1:0]  sum;
    logic          cout, err;
    logic [1:0]    err_seg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    int mcnt = 0;
    bit merr = 1'b0;
    int mseg = 0;

    always #2.5 clk = ~clk;

    seg_vote_adder u_seg_vote_adder (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .cin(cin),
        .fault_en(fault_en), .fault_seg(fault_seg), .sum(sum), .cout(cout),
        .err(err), .err_seg(err_seg)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] v);
        logic [31:0] r;
        r = v ^ (v << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        return r;
    endfunction

    // Starts just after a negedge: drive, check, clock, update model, reach next negedge
    task automatic cycle(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                         input logic fe, input logic [1:0] fs);
        logic [W:0]   exp_full;
        logic [W-1:0] exp_sum;
        string        tag;
        bit           inv;
        op_a = a; op_b = b; cin = c; fault_en = fe; fault_seg = fs;
        #1;
        exp_full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        exp_sum  = exp_full[W-1:0];
        inv = fe && !(merr && mseg == int'(fs)) && (mcnt != int'(fs));
        if (inv) exp_sum = exp_sum ^ (16'hF << (int'(fs) * SEG_W));
        if (!fe)                             tag = "R1";
        else if (merr && mseg == int'(fs))   tag = "R6";
        else if (mcnt == int'(fs))           tag = "R3";
        else if (merr)                       tag = "R7";
        else                                 tag = "R4";
        check(sum == exp_sum, tag, {16'h0, sum}, {16'h0, exp_sum});
        check(cout == exp_full[W], fe ? "R10" : "R1", {31'h0, cout}, {31'h0, exp_full[W]});
        check(err == merr, "R5", {31'h0, err}, {31'h0, merr});
        check(int'(err_seg) == (merr ? mseg : 0), "R5", {30'h0, err_seg}, merr ? mseg : 0);
        @(posedge clk);
        if (!merr) begin
            if (fe && int'(fs) == mcnt) begin
                merr = 1'b1;
                mseg = mcnt;
            end else begin
                mcnt = (mcnt + 1) % N_SEG;
            end
        end
        @(negedge clk);
    endtask

    task automatic rand_cycle(input logic fe, input logic [1:0] fs);
        logic [31:0] v;
        rng = next_rng(rng);
        v = rng;
        rng = next_rng(rng);
        cycle(v[15:0], v[31:16], rng[7], fe, fs);
    endtask

    // Synchronous reset, checked while held, released at a negedge
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fault_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(err == 1'b0, "R9", {31'h0, err}, 32'h0);
        check(err_seg == 2'd0, "R9", {30'h0, err_seg}, 32'h0);
        rst_n = 1'b1;
        mcnt = 0; merr = 1'b0; mseg = 0;
    endtask

    initial begin
        do_reset();
        // R1: corner operands and a broad pseudo-random sweep
        cycle(16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0);
        cycle(16'hFFFF, 16'h0000, 1'b1, 1'b0, 2'd0);
        cycle(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 2'd0);
        cycle(16'hFFFF, 16'h0001, 1'b0, 1'b0, 2'd0);
        cycle(16'h8000, 16'h8000, 1'b0, 1'b0, 2'd0);
        cycle(16'h0FFF, 16'h0001, 1'b0, 1'b0, 2'd0);
        cycle(16'h0F0F, 16'hF0F0, 1'b1, 1'b0, 2'd0);
        for (int i = 0; i < 3000; i++) rand_cycle(1'b0, 2'd0);

        // Every fault segment at every start offset of the rotation
        for (int f = 0; f < N_SEG; f++) begin
            for (int d = 0; d < 5; d++) begin
                int lat;
                int exp_lat;
                do_reset();
                for (int i = 0; i < d; i++) rand_cycle(1'b0, 2'd0);
                exp_lat = ((f - (d % N_SEG) + N_SEG) % N_SEG) + 1;
                lat = 0;
                for (int i = 0; i < 6; i++) begin
                    rand_cycle(1'b1, 2'(f));
                    lat++;
                    if (err) break;
                end
                check(lat >= 1 && lat <= 4 && err, "R8", lat, exp_lat);
                check(lat == exp_lat, "R8", lat, exp_lat);
                if (d == 0) check(lat == f + 1, "R2", lat, f + 1);
                // R6: repaired slot stays correct while the fault persists
                for (int i = 0; i < 4; i++) rand_cycle(1'b1, 2'(f));
                // R5: flag and index remain once the fault is removed
                for (int i = 0; i < 2; i++) rand_cycle(1'b0, 2'd0);
                // R7: a second fault elsewhere is visible and unreported
                for (int i = 0; i < 5; i++) rand_cycle(1'b1, 2'((f + 1) % N_SEG));
                check(int'(err_seg) == f, "R7", {30'h0, err_seg}, f);
            end
        end
        do_reset();
        rand_cycle(1'b0, 2'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule